// File: doc/BRIEF.md
# SPI Serial Programming Target

This block is the target side of a serial in-system programming link. It holds a small Flash byte array and a small EEPROM byte array. An external programmer drives a serial clock, a data-in line and a programming-reset line, and reads replies on a data-out line. All three inputs cross into the system clock domain through two-flop synchronizers. The serial clock is then filtered, so that a level change counts only after it has held for a minimum number of system clocks.

Each instruction is four bytes long and is shifted in most significant bit first. The programmer has to hold the programming-reset line low and open the session with an enable handshake. Only after that do erase, write, read and poll instructions take effect. Every erase or write starts a self-timed busy window, and the programmer can watch that window with the poll instruction. Writes to Flash can only clear bits. Writes to EEPROM replace the stored byte, because the old byte is erased first as part of the same timed cycle.

Top module: `spi_prog_target`

## Requirements
- R1: While the synchronized `prog_rst_i` is 1, the block is idle. The enable state is cleared, the bit and byte position restarts at zero, and `miso_o` is 0. Taking `prog_rst_i` high in the middle of an instruction abandons that instruction. The next instruction is framed from its first bit.
- R2: After `prog_rst_i` goes low, the erase, write, read and poll instructions have no effect until an enable instruction completes. The enable instruction is first byte 0xAC and second byte 0x53. Until then, the fourth reply byte is an echo of the third byte received.
- R3: The first reply byte of every instruction is 0x00. The second, third and fourth reply bytes echo the previously received byte, except where R7 or R8 applies. In particular, 0x53 is returned during the third byte of the enable instruction.
- R4: Chip erase (0xAC 0x80 xx xx) sets every Flash byte and every EEPROM byte to 0xFF.
- R5: A Flash write (0x40 xx addr data) stores the bitwise AND of the old byte and the data byte, so a write can only clear bits.
- R6: An EEPROM write (0xC0 xx addr data) stores the data byte exactly, whatever the old contents, with no erase needed beforehand.
- R7: A Flash read (0x20 xx addr xx) or an EEPROM read (0xA0 xx addr xx) returns the addressed byte as the fourth reply byte. The address is taken modulo the array depth.
- R8: An accepted erase or write keeps the block busy for BUSY_CYCLES system clocks. A poll (0xF0 xx xx xx) returns 0x01 as its fourth reply byte while busy and 0x00 otherwise.
- R9: An erase or write that completes while the block is busy is dropped and leaves both arrays unchanged.
- R10: The filtered serial clock changes level only after the synchronized input has held the new level for 3 consecutive system clocks (FAST_CLK=0) or 4 (FAST_CLK=1). A shorter pulse produces no data sample and no shift of the reply.
- R11: `mosi_i` is sampled at the filtered rising edge. `miso_o` changes only at the filtered falling edge, or when `prog_rst_i` goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| prog_rst_i | input | 1 | Programming reset; the link is active while it is low |
| sck_i | input | 1 | Serial clock from the programmer |
| mosi_i | input | 1 | Serial data from the programmer |
| miso_o | output | 1 | Serial reply data to the programmer |

## Verification
The four-byte exchange is exercised first before the enable handshake and then after it, which separates ignored commands from accepted ones by the echoed versus returned fourth byte. Flash and EEPROM writes are each repeated to the same address with different data. The AND result on one array and the plain overwrite on the other show the auto-erase difference. A write issued inside the busy window, and polls placed on both sides of that window, tell dropped commands apart from accepted ones. Short serial-clock pulses placed inside a low phase, and a programming reset raised in mid-instruction, must leave the following transfers exactly as a clean run would.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

  localparam logic [7:0] OP_SYS   = 8'hAC;
  localparam logic [7:0] SUB_EN   = 8'h53;
  localparam logic [7:0] SUB_ERA  = 8'h80;
  localparam logic [7:0] OP_FWR   = 8'h40;
  localparam logic [7:0] OP_EWR   = 8'hC0;
  localparam logic [7:0] OP_FRD   = 8'h20;
  localparam logic [7:0] OP_ERD   = 8'hA0;
  localparam logic [7:0] OP_POLL  = 8'hF0;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_ENABLE,
    CMD_ERASE,
    CMD_FWR,
    CMD_EWR,
    CMD_FRD,
    CMD_ERD,
    CMD_POLL
  } cmd_e;

  function automatic cmd_e decode_cmd(logic [7:0] op, logic [7:0] sub);
    cmd_e c;
    case (op)
      OP_SYS:  c = (sub == SUB_EN) ? CMD_ENABLE :
                   (sub == SUB_ERA) ? CMD_ERASE : CMD_NONE;
      OP_FWR:  c = CMD_FWR;
      OP_EWR:  c = CMD_EWR;
      OP_FRD:  c = CMD_FRD;
      OP_ERD:  c = CMD_ERD;
      OP_POLL: c = CMD_POLL;
      default: c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/spi_prog_sync.sv
module spi_prog_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/spi_prog_phase_filt.sv
module spi_prog_phase_filt #(
  parameter int MIN_PHASE = 3,
  parameter int CNT_W     = $clog2(MIN_PHASE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);

  logic             lvl_q, lvl_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             flip;

  always_comb begin
    lvl_n = lvl_q;
    cnt_n = '0;
    flip  = 1'b0;
    if (lvl_i != lvl_q) begin
      if (cnt_q == CNT_W'(MIN_PHASE - 1)) begin
        flip  = 1'b1;
        lvl_n = lvl_i;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      lvl_q <= lvl_n;
      cnt_q <= cnt_n;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = flip & lvl_i;
  assign fall_o = flip & ~lvl_i;

endmodule

// File: rtl/spi_prog_mem.sv
module spi_prog_mem #(
  parameter int DEPTH     = 16,
  parameter bit AND_WRITE = 1'b0,
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] wr_val;

  assign rdata_o = mem_q[addr_i];

  generate
    if (AND_WRITE) begin : g_clear_only
      assign wr_val = mem_q[addr_i] & wdata_i;
    end else begin : g_auto_erase
      assign wr_val = wdata_i;
    end
  endgenerate

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    logic [7:0] cell_n;
    logic       cell_en;

    always_comb begin
      cell_en = erase_i | (we_i && (addr_i == AW'(gi)));
      cell_n  = erase_i ? 8'hFF : wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[gi] <= 8'hFF;
      end else if (cell_en) begin
        mem_q[gi] <= cell_n;
      end
    end
  end

endmodule

// File: rtl/spi_prog_target.sv
module spi_prog_target
  import spi_prog_pkg::*;
#(
  parameter int FLASH_DEPTH = 16,
  parameter int EE_DEPTH    = 8,
  parameter int BUSY_CYCLES = 1000,
  parameter bit FAST_CLK    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_rst_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic miso_o
);

  localparam int MIN_PHASE = FAST_CLK ? 4 : 3;
  localparam int FLASH_AW  = $clog2(FLASH_DEPTH);
  localparam int EE_AW     = $clog2(EE_DEPTH);
  localparam int BUSY_W    = $clog2(BUSY_CYCLES + 1);

  // synchronized inputs
  logic [2:0] in_s;
  logic       rst_s, sck_s, mosi_s, active;

  spi_prog_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({prog_rst_i, sck_i, mosi_i}),
    .q_o   (in_s)
  );

  assign rst_s  = in_s[2];
  assign sck_s  = in_s[1];
  assign mosi_s = in_s[0];
  assign active = ~rst_s;

  logic sck_f, sck_rise, sck_fall;

  spi_prog_phase_filt #(.MIN_PHASE(MIN_PHASE)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (sck_s),
    .lvl_o  (sck_f),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  // state
  logic [2:0]        bit_cnt_q, bit_cnt_n;
  logic [1:0]        byte_cnt_q, byte_cnt_n;
  logic [7:0]        rx_q, rx_n;
  logic [7:0]        hist_q [3];
  logic [7:0]        hist_n [3];
  logic [7:0]        tx_q, tx_n;
  logic              en_q, en_n;
  logic [BUSY_W-1:0] busy_q, busy_n;

  logic       busy;
  logic [7:0] byte_full;
  logic [7:0] out_byte;
  logic [7:0] flash_rd, ee_rd;
  logic       commit, ok_wr;
  logic       flash_we, ee_we, erase;
  cmd_e       cmd;

  assign busy      = (busy_q != '0);
  assign cmd       = decode_cmd(hist_q[0], hist_q[1]);
  assign byte_full = {rx_q[6:0], mosi_s};
  assign commit    = active && sck_rise && (bit_cnt_q == 3'd7) && (byte_cnt_q == 2'd3);
  assign ok_wr     = en_q && !busy;
  assign erase     = commit && ok_wr && (cmd == CMD_ERASE);
  assign flash_we  = commit && ok_wr && (cmd == CMD_FWR);
  assign ee_we     = commit && ok_wr && (cmd == CMD_EWR);

  spi_prog_mem #(.DEPTH(FLASH_DEPTH), .AND_WRITE(1'b1)) u_flash (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase_i (erase),
    .we_i    (flash_we),
    .addr_i  (hist_q[2][FLASH_AW-1:0]),
    .wdata_i (byte_full),
    .rdata_o (flash_rd)
  );

  spi_prog_mem #(.DEPTH(EE_DEPTH), .AND_WRITE(1'b0)) u_ee (
    .clk     (clk),
    .rst_n   (rst_n),
    .erase_i (erase),
    .we_i    (ee_we),
    .addr_i  (hist_q[2][EE_AW-1:0]),
    .wdata_i (byte_full),
    .rdata_o (ee_rd)
  );

  // reply byte selected for the byte about to be shifted out
  always_comb begin
    out_byte = 8'h00;
    case (byte_cnt_q)
      2'd0: out_byte = 8'h00;
      2'd1: out_byte = hist_q[0];
      2'd2: out_byte = hist_q[1];
      default: begin
        out_byte = hist_q[2];
        if (en_q) begin
          if (cmd == CMD_FRD)       out_byte = flash_rd;
          else if (cmd == CMD_ERD)  out_byte = ee_rd;
          else if (cmd == CMD_POLL) out_byte = {7'd0, busy};
        end
      end
    endcase
  end

  always_comb begin
    bit_cnt_n  = bit_cnt_q;
    byte_cnt_n = byte_cnt_q;
    rx_n       = rx_q;
    hist_n     = hist_q;
    tx_n       = tx_q;
    en_n       = en_q;
    busy_n     = busy ? busy_q - 1'b1 : busy_q;

    if (!active) begin
      bit_cnt_n  = '0;
      byte_cnt_n = '0;
      rx_n       = '0;
      tx_n       = '0;
      en_n       = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_n      = byte_full;
        bit_cnt_n = bit_cnt_q + 1'b1;
        if (bit_cnt_q == 3'd7) begin
          byte_cnt_n = byte_cnt_q + 1'b1;
          if (byte_cnt_q != 2'd3) begin
            hist_n[byte_cnt_q] = byte_full;
          end
        end
      end
      if (sck_fall) begin
        tx_n = (bit_cnt_q == 3'd0) ? out_byte : {tx_q[6:0], 1'b0};
      end
      if (commit && (cmd == CMD_ENABLE)) begin
        en_n = 1'b1;
      end
      if (erase || flash_we || ee_we) begin
        busy_n = BUSY_W'(BUSY_CYCLES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q  <= '0;
      byte_cnt_q <= '0;
      rx_q       <= '0;
      hist_q[0]  <= '0;
      hist_q[1]  <= '0;
      hist_q[2]  <= '0;
      tx_q       <= '0;
      en_q       <= 1'b0;
      busy_q     <= '0;
    end else begin
      bit_cnt_q  <= bit_cnt_n;
      byte_cnt_q <= byte_cnt_n;
      rx_q       <= rx_n;
      hist_q     <= hist_n;
      tx_q       <= tx_n;
      en_q       <= en_n;
      busy_q     <= busy_n;
    end
  end

  assign miso_o = tx_q[7];

endmodule

// File: rtl/spi_prog_target_chk.sv
module spi_prog_target_chk #(
  parameter int MIN_PHASE = 3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_s,
  input logic       sck_s,
  input logic       sck_f,
  input logic       en_q,
  input logic       busy,
  input logic       erase,
  input logic       flash_we,
  input logic       ee_we,
  input logic [2:0] bit_cnt_q,
  input logic [1:0] byte_cnt_q,
  input logic       miso_o
);

  // consecutive cycles the synchronized clock has been high, saturating
  logic [3:0] hi_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q <= '0;
    end else if (!sck_s) begin
      hi_run_q <= '0;
    end else if (hi_run_q != 4'hF) begin
      hi_run_q <= hi_run_q + 1'b1;
    end
  end

  logic any_wr;
  assign any_wr = erase | flash_we | ee_we;

  assert_idle_on_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_s |=> (!en_q && bit_cnt_q == 3'd0 && byte_cnt_q == 2'd0 && !miso_o));

  assert_write_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> en_q);

  assert_write_starts_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> busy);

  assert_no_write_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |-> !busy);

  assert_rise_after_min_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck_f) |-> (hi_run_q >= 4'(MIN_PHASE)));

  assert_miso_steady_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sck_f && $past(sck_f) && !$past(rst_s)) |-> $stable(miso_o));

endmodule

bind spi_prog_target spi_prog_target_chk #(.MIN_PHASE(MIN_PHASE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_s      (rst_s),
  .sck_s      (sck_s),
  .sck_f      (sck_f),
  .en_q       (en_q),
  .busy       (busy),
  .erase      (erase),
  .flash_we   (flash_we),
  .ee_we      (ee_we),
  .bit_cnt_q  (bit_cnt_q),
  .byte_cnt_q (byte_cnt_q),
  .miso_o     (miso_o)
);

// File: tb/spi_prog_target_test.sv
`timescale 1ns/1ps
module spi_prog_target_test;

  localparam int FD   = 16;
  localparam int ED   = 8;
  localparam int BUSY = 2000;
  localparam int HALF = 10;
  localparam int WAIT = 2300;

  logic clk, rst_n, prog_rst, sck, mosi, miso;

  spi_prog_target #(.FLASH_DEPTH(FD), .EE_DEPTH(ED), .BUSY_CYCLES(BUSY), .FAST_CLK(1'b0)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_rst_i (prog_rst),
    .sck_i      (sck),
    .mosi_i     (mosi),
    .miso_o     (miso)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int  tests, fails, cyc;
  bit  done;

  always @(posedge clk) cyc <= cyc + 1;

  // behavioural reference state
  logic [7:0] flash_m [FD];
  logic [7:0] ee_m [ED];
  bit         en_m;
  int         busy_until;

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] ins, input bit glitch, output logic [31:0] resp);
    for (int i = 31; i >= 0; i--) begin
      mosi = ins[i];
      clks(HALF);
      resp[i] = miso;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
      if (glitch && (i % 5 == 0)) begin
        clks(8);
        sck = 1'b1;      // too short to count as a phase
        clks(2);
        sck = 1'b0;
      end
    end
  endtask

  // one instruction: predict replies, run it, compare, update model
  task automatic op(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                    input logic [7:0] d, input bit glitch, input string tag4);
    logic [31:0] resp;
    logic [7:0]  exp4;
    int          t0;
    t0   = cyc;
    exp4 = c;
    if (en_m) begin
      if (a == 8'h20)      exp4 = flash_m[c % FD];
      else if (a == 8'hA0) exp4 = ee_m[c % ED];
      else if (a == 8'hF0) exp4 = {7'd0, (t0 < busy_until)};
    end
    xfer({a, b, c, d}, glitch, resp);
    chk("R3 byte1", resp[31:24], 8'h00);
    chk("R3 byte2", resp[23:16], a);
    chk("R3 byte3", resp[15:8], b);
    chk(tag4, resp[7:0], exp4);
    if (a == 8'hAC && b == 8'h53) begin
      en_m = 1'b1;
    end else if (en_m && cyc >= busy_until) begin
      if (a == 8'hAC && b == 8'h80) begin
        for (int k = 0; k < FD; k++) flash_m[k] = 8'hFF;
        for (int k = 0; k < ED; k++) ee_m[k] = 8'hFF;
        busy_until = cyc + BUSY;
      end else if (a == 8'h40) begin
        flash_m[c % FD] = flash_m[c % FD] & d;
        busy_until = cyc + BUSY;
      end else if (a == 8'hC0) begin
        ee_m[c % ED] = d;
        busy_until = cyc + BUSY;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < FD; k++) flash_m[k] = 8'hFF;
    for (int k = 0; k < ED; k++) ee_m[k] = 8'hFF;
    en_m = 1'b0; busy_until = 0;
    rst_n = 1'b0; prog_rst = 1'b1; sck = 1'b0; mosi = 1'b0;
    clks(5);
    rst_n = 1'b1;
    clks(10);
    chk("R1 reset miso", {7'd0, miso}, 8'h00);
    prog_rst = 1'b0;
    clks(10);

    // R2: commands before enable are ignored, fourth byte echoes
    op(8'h40, 8'h00, 8'h03, 8'h12, 1'b0, "R2 write before enable");
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b0, "R2 read before enable echoes");
    op(8'hF0, 8'h00, 8'h07, 8'h00, 1'b0, "R2 poll before enable echoes");
    // enable handshake, echo 0x53 in third byte (R3)
    op(8'hAC, 8'h53, 8'h00, 8'h00, 1'b0, "R3 enable fourth byte");
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b0, "R2 R7 flash untouched");

    // R5: flash clears bits only
    op(8'h40, 8'h00, 8'h03, 8'h5A, 1'b0, "R3 flash write");
    clks(WAIT);
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b0, "R5 R7 flash read 5A");
    op(8'h40, 8'h00, 8'h03, 8'hF0, 1'b0, "R3 flash write");
    clks(WAIT);
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b0, "R5 flash AND result");

    // R6, R8, R9: eeprom write, dropped write while busy, polls
    op(8'hC0, 8'h00, 8'h02, 8'h3C, 1'b0, "R3 ee write");
    op(8'hC0, 8'h00, 8'h02, 8'h77, 1'b0, "R9 ee write while busy");
    op(8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, "R8 poll busy");
    clks(WAIT);
    op(8'hF0, 8'h00, 8'h00, 8'h00, 1'b0, "R8 poll idle");
    op(8'hA0, 8'h00, 8'h02, 8'h00, 1'b0, "R9 R7 ee read keeps 3C");
    op(8'hC0, 8'h00, 8'h02, 8'hC3, 1'b0, "R3 ee write");
    clks(WAIT);
    op(8'hA0, 8'h00, 8'h02, 8'h00, 1'b0, "R6 ee auto-erase C3");

    // R7: address wraps modulo depth
    op(8'h20, 8'h00, 8'h13, 8'h00, 1'b0, "R7 flash addr wrap");
    op(8'hA0, 8'h00, 8'h0A, 8'h00, 1'b0, "R7 ee addr wrap");

    // R10: short SCK pulses in the low phases add no samples
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b1, "R10 R11 glitched read");

    // R4: chip erase
    op(8'hAC, 8'h80, 8'h00, 8'h00, 1'b0, "R3 erase");
    clks(WAIT);
    op(8'h20, 8'h00, 8'h03, 8'h00, 1'b0, "R4 flash erased");
    op(8'hA0, 8'h00, 8'h02, 8'h00, 1'b0, "R4 ee erased");

    // R1: abort mid-instruction
    for (int i = 31; i >= 20; i--) begin
      mosi = 1'b1; clks(HALF); sck = 1'b1; clks(HALF); sck = 1'b0;
    end
    prog_rst = 1'b1;
    clks(20);
    chk("R1 miso idle in reset", {7'd0, miso}, 8'h00);
    en_m = 1'b0;
    prog_rst = 1'b0;
    clks(10);
    op(8'h20, 8'h00, 8'h05, 8'h00, 1'b0, "R1 R2 enable lost after reset");
    op(8'hAC, 8'h53, 8'h00, 8'h00, 1'b0, "R1 enable after abort");
    op(8'hC0, 8'h00, 8'h05, 8'h11, 1'b0, "R3 ee write");
    clks(WAIT);
    op(8'hA0, 8'h00, 8'h05, 8'h00, 1'b0, "R1 R6 framing restored");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule